// File: doc/BRIEF.md
# Trap entry sequencer

This block carries out the entry half of a software trap on a 32-bit processor core. When the core raises a trap request with an 8-bit trap number, the sequencer takes a snapshot of the current program counter, the status word, the system stack pointer and the table base register. It then writes two words onto the system stack and reads the handler address from a vector table. Finally it hands back the new program counter together with one-cycle update pulses for the stack pointer and the status bits. A second request input starts the emulator-trap variant. That variant always uses vector 9, raises the interrupt level to 4 and leaves the interrupt-enable bit alone.

The vector table fills a 1 KiB window that starts at the table base. Vector N sits at byte offset 1024 − 4·(N+1), so vector 0 is the top word of the window and vector 255 is the bottom word. Memory traffic goes through one word-wide port with a write strobe, a read strobe and a ready return. Each memory step keeps its request asserted until ready is seen.

The controller is a five-state machine. IDLE moves to PUSH_PS when a request is accepted. PUSH_PS moves to PUSH_PC on ready. PUSH_PC moves to FETCH_VEC on ready. FETCH_VEC moves to DONE on ready. DONE always returns to IDLE after one cycle.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, busy, done, mem_wr and mem_rd are all 0.
- R2: In IDLE, a high trap_req or emu_req is accepted at the clock edge. If both are high, emu_req wins. busy is 1 from the cycle after acceptance through the DONE cycle inclusive, and returns to 0 after that.
- R3: The first memory access is a write of the captured status word to address sp − 4.
- R4: The second memory access is a write of the captured PC + 2 to address sp − 8.
- R5: The third memory access is a read from table_base + 1024 − 4·(N+1), computed modulo 2^32, where N is the captured 8-bit trap number.
- R6: For an emulator trap, N is 9. In the DONE cycle level_we is 1, level_val is 4 and ie_clr is 0.
- R7: For an ordinary trap, ie_clr is 1 and level_we is 0 in the DONE cycle.
- R8: done is high for exactly one cycle. In that cycle new_pc equals the word read in R5, sp_we is 1 with sp_new = sp − 8 (modulo 2^32), and stack_sel_clr is 1. sp_we, ie_clr, level_we and stack_sel_clr are 0 in every other cycle.
- R9: While mem_wr or mem_rd is high and mem_ready is low, the request, the address and the write data stay unchanged in the next cycle.
- R10: trap_req and emu_req have no effect while busy: no extra memory access and no extra done pulse follow.
- R11: mem_wr and mem_rd are never high together, and the accesses happen in the order of R3, R4, R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Ordinary trap request |
| emu_req | input | 1 | Emulator-trap request (vector 9) |
| trap_num | input | 8 | Trap number of an ordinary trap |
| cur_pc | input | 32 | PC of the trapping instruction |
| cur_status | input | 32 | Current status word |
| sys_sp | input | 32 | Current system stack pointer |
| tbl_base | input | 32 | Vector table base |
| mem_wr | output | 1 | Memory write request |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| new_pc | output | 32 | Handler address, valid with done |
| sp_we | output | 1 | Stack pointer write pulse |
| sp_new | output | 32 | New system stack pointer |
| stack_sel_clr | output | 1 | Pulse: select the system stack |
| ie_clr | output | 1 | Pulse: clear interrupt enable |
| level_we | output | 1 | Pulse: write interrupt level |
| level_val | output | 5 | Interrupt level value |

## Verification
The case that is hardest to reach from the ports is a request that arrives while a sequence is stalled in the middle of its stack pushes. The request must leave no trace: no second frame is written and no extra done pulse appears. To get there, the bench holds off mem_ready for several cycles so the sequencer stays in its write states, and pulses trap_req with another trap number during that stall. The scoreboard then treats any memory access or done pulse that it did not queue as a failure. Wrap cases get their own stimulus: a table base near the top of the address space, and a stack pointer of 4.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PS,
        ST_PUSH_PC,
        ST_FETCH_VEC,
        ST_DONE
    } trap_state_e;

endpackage

// File: rtl/trap_vec_addr.sv
// Vector slot address: slots grow downward from the top of the table window.
module trap_vec_addr #(
    parameter int AW         = 32,
    parameter int NUM_W      = 8,
    parameter int TBL_BYTES  = 1024,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0]    base,
    input  logic [NUM_W-1:0] num,
    output logic [AW-1:0]    slot_addr
);
    localparam logic [AW-1:0] TOP  = AW'(TBL_BYTES);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] slot_idx;

    always_comb begin
        slot_idx  = AW'(num) + AW'(1);
        slot_addr = base + TOP - (slot_idx * STEP);
    end
endmodule

// File: rtl/trap_frame.sv
// Captures the trap context at acceptance and the handler word at fetch.
module trap_frame #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int NUM_W      = 8,
    parameter int TBL_BYTES  = 1024,
    parameter int WORD_BYTES = 4,
    parameter int PC_STEP    = 2,
    parameter int EMU_VEC    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             emu_sel,
    input  logic [NUM_W-1:0] num_in,
    input  logic [AW-1:0]    pc_in,
    input  logic [DW-1:0]    status_in,
    input  logic [AW-1:0]    sp_in,
    input  logic [AW-1:0]    base_in,
    input  logic             vec_load,
    input  logic [DW-1:0]    vec_data,
    output logic [DW-1:0]    status_q,
    output logic [AW-1:0]    ret_pc_q,
    output logic [AW-1:0]    sp_minus1,
    output logic [AW-1:0]    sp_minus2,
    output logic [AW-1:0]    vec_addr,
    output logic             emu_q,
    output logic [DW-1:0]    handler_q
);
    localparam logic [AW-1:0] WSTEP = AW'(WORD_BYTES);

    logic [AW-1:0]    sp_q;
    logic [AW-1:0]    base_q;
    logic [NUM_W-1:0] num_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            ret_pc_q <= '0;
            sp_q     <= '0;
            base_q   <= '0;
            num_q    <= '0;
            emu_q    <= 1'b0;
        end else if (capture) begin
            status_q <= status_in;
            ret_pc_q <= pc_in + AW'(PC_STEP);
            sp_q     <= sp_in;
            base_q   <= base_in;
            num_q    <= emu_sel ? NUM_W'(EMU_VEC) : num_in;
            emu_q    <= emu_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        handler_q <= '0;
        else if (vec_load) handler_q <= vec_data;
    end

    assign sp_minus1 = sp_q - WSTEP;
    assign sp_minus2 = sp_q - (WSTEP + WSTEP);

    trap_vec_addr #(
        .AW(AW), .NUM_W(NUM_W), .TBL_BYTES(TBL_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_vec (
        .base      (base_q),
        .num       (num_q),
        .slot_addr (vec_addr)
    );
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int NUM_W      = 8,
    parameter int LVL_W      = 5,
    parameter int TBL_BYTES  = 1024,
    parameter int WORD_BYTES = 4,
    parameter int PC_STEP    = 2,
    parameter int EMU_VEC    = 9,
    parameter int EMU_LEVEL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic             emu_req,
    input  logic [NUM_W-1:0] trap_num,
    input  logic [AW-1:0]    cur_pc,
    input  logic [DW-1:0]    cur_status,
    input  logic [AW-1:0]    sys_sp,
    input  logic [AW-1:0]    tbl_base,
    output logic             mem_wr,
    output logic             mem_rd,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    new_pc,
    output logic             sp_we,
    output logic [AW-1:0]    sp_new,
    output logic             stack_sel_clr,
    output logic             ie_clr,
    output logic             level_we,
    output logic [LVL_W-1:0] level_val
);
    trap_state_e state_q, state_d;

    logic          accept;
    logic [DW-1:0] f_status;
    logic [AW-1:0] f_ret_pc;
    logic [AW-1:0] f_sp_m1;
    logic [AW-1:0] f_sp_m2;
    logic [AW-1:0] f_vec_addr;
    logic          f_emu;
    logic [DW-1:0] f_handler;

    assign accept = (state_q == ST_IDLE) && (trap_req || emu_req);

    trap_frame #(
        .AW(AW), .DW(DW), .NUM_W(NUM_W), .TBL_BYTES(TBL_BYTES),
        .WORD_BYTES(WORD_BYTES), .PC_STEP(PC_STEP), .EMU_VEC(EMU_VEC)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .emu_sel   (emu_req),
        .num_in    (trap_num),
        .pc_in     (cur_pc),
        .status_in (cur_status),
        .sp_in     (sys_sp),
        .base_in   (tbl_base),
        .vec_load  ((state_q == ST_FETCH_VEC) && mem_ready),
        .vec_data  (mem_rdata),
        .status_q  (f_status),
        .ret_pc_q  (f_ret_pc),
        .sp_minus1 (f_sp_m1),
        .sp_minus2 (f_sp_m2),
        .vec_addr  (f_vec_addr),
        .emu_q     (f_emu),
        .handler_q (f_handler)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept)    state_d = ST_PUSH_PS;
            ST_PUSH_PS:   if (mem_ready) state_d = ST_PUSH_PC;
            ST_PUSH_PC:   if (mem_ready) state_d = ST_FETCH_VEC;
            ST_FETCH_VEC: if (mem_ready) state_d = ST_DONE;
            ST_DONE:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_wr        = 1'b0;
        mem_rd        = 1'b0;
        mem_addr      = '0;
        mem_wdata     = '0;
        busy          = 1'b1;
        done          = 1'b0;
        new_pc        = '0;
        sp_we         = 1'b0;
        sp_new        = '0;
        stack_sel_clr = 1'b0;
        ie_clr        = 1'b0;
        level_we      = 1'b0;
        level_val     = '0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_PUSH_PS: begin
                mem_wr    = 1'b1;
                mem_addr  = f_sp_m1;
                mem_wdata = f_status;
            end
            ST_PUSH_PC: begin
                mem_wr    = 1'b1;
                mem_addr  = f_sp_m2;
                mem_wdata = f_ret_pc;
            end
            ST_FETCH_VEC: begin
                mem_rd   = 1'b1;
                mem_addr = f_vec_addr;
            end
            ST_DONE: begin
                done          = 1'b1;
                new_pc        = f_handler;
                sp_we         = 1'b1;
                sp_new        = f_sp_m2;
                stack_sel_clr = 1'b1;
                ie_clr        = !f_emu;
                level_we      = f_emu;
                level_val     = f_emu ? LVL_W'(EMU_LEVEL) : '0;
            end
            default: busy = 1'b0;
        endcase
    end

    // R11
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_wr || mem_rd) && !mem_ready) |=>
        ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wr) && $stable(mem_rd)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    fetch_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd && mem_ready));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R8
    pulse_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we || stack_sel_clr || ie_clr || level_we) |-> done);
endmodule

// File: tb/trap_entry_seq_test.sv
module trap_entry_seq_test;
    localparam logic [31:0] KEY = 32'hA5A5_0F0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic        emu_req = 1'b0;
    logic [7:0]  trap_num = '0;
    logic [31:0] cur_pc = '0, cur_status = '0, sys_sp = '0, tbl_base = '0;
    logic        mem_wr, mem_rd;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy, done, sp_we, stack_sel_clr, ie_clr, level_we;
    logic [31:0] new_pc, sp_new;
    logic [4:0]  level_val;

    always #4 clk = ~clk;

    trap_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .emu_req(emu_req),
        .trap_num(trap_num), .cur_pc(cur_pc), .cur_status(cur_status),
        .sys_sp(sys_sp), .tbl_base(tbl_base), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .new_pc(new_pc),
        .sp_we(sp_we), .sp_new(sp_new), .stack_sel_clr(stack_sel_clr),
        .ie_clr(ie_clr), .level_we(level_we), .level_val(level_val)
    );

    typedef struct {
        int          kind;   // 0 status push, 1 pc push, 2 vector read, 3 done
        logic [31:0] addr;
        logic [31:0] data;
        logic        ie;
        logic        lw;
        logic [4:0]  lv;
    } exp_t;

    exp_t sb[$];
    int   tests = 0;
    int   fails = 0;
    int   wait_cfg = 0;
    int   wcnt = 0;
    int   done_seen = 0;
    int   cyc = 0;
    logic prev_done = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Memory responder and monitor: decides ready for the next edge and
    // compares each completing access against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            mem_ready = 1'b0;
            if (prev_done) begin
                chk(!done && !sp_we && !ie_clr && !level_we && !stack_sel_clr,
                    "R8 pulses after done", {27'd0, done, sp_we, ie_clr, level_we, stack_sel_clr}, 32'd0);
            end
            prev_done = done;
            if (mem_wr || mem_rd) begin
                if (wcnt >= wait_cfg) begin
                    // R9: address/data compared after any stall cycles
                    exp_t e;
                    mem_ready = 1'b1;
                    wcnt = 0;
                    chk(busy, "R2 busy during access", {31'd0, busy}, 32'd1);
                    if (sb.size() == 0) begin
                        chk(1'b0, "R10 unexpected access", mem_addr, 32'd0);
                    end else begin
                        e = sb.pop_front();
                        if (e.kind == 0)
                            chk(mem_wr && mem_addr == e.addr && mem_wdata == e.data,
                                "R3 status push", mem_addr ^ mem_wdata, e.addr ^ e.data);
                        else if (e.kind == 1)
                            chk(mem_wr && mem_addr == e.addr && mem_wdata == e.data,
                                "R4 return push", mem_addr ^ mem_wdata, e.addr ^ e.data);
                        else if (e.kind == 2)
                            chk(mem_rd && !mem_wr && mem_addr == e.addr,
                                "R5 R11 vector read", mem_addr, e.addr);
                        else
                            chk(1'b0, "R11 access order", mem_addr, 32'd0);
                    end
                    if (mem_rd) mem_rdata = mem_addr ^ KEY;
                end else begin
                    wcnt++;
                end
            end else begin
                wcnt = 0;
            end
            if (done) begin
                exp_t e;
                done_seen++;
                if (sb.size() == 0 || sb[0].kind != 3) begin
                    chk(1'b0, "R10 unexpected done", new_pc, 32'd0);
                end else begin
                    e = sb.pop_front();
                    chk(new_pc == e.data, "R8 new_pc", new_pc, e.data);
                    chk(sp_we && stack_sel_clr && busy && sp_new == e.addr,
                        "R8 stack pointer update", sp_new, e.addr);
                    chk(ie_clr == e.ie && level_we == e.lw && level_val == e.lv,
                        "R6 R7 status bits", {25'd0, ie_clr, level_we, level_val},
                        {25'd0, e.ie, e.lw, e.lv});
                end
            end
        end
    end

    task automatic run_trap(input logic t, input logic em, input logic [7:0] n,
                            input logic [31:0] pc, input logic [31:0] st,
                            input logic [31:0] sp, input logic [31:0] base,
                            input int w, input logic inject);
        logic [7:0]  en;
        logic [31:0] va;
        int          start;
        en = em ? 8'd9 : n;
        va = base + 32'd1024 - 32'd4 * ({24'd0, en} + 32'd1);
        sb.push_back('{0, sp - 32'd4, st, 1'b0, 1'b0, 5'd0});
        sb.push_back('{1, sp - 32'd8, pc + 32'd2, 1'b0, 1'b0, 5'd0});
        sb.push_back('{2, va, 32'd0, 1'b0, 1'b0, 5'd0});
        sb.push_back('{3, sp - 32'd8, va ^ KEY, !em, em, em ? 5'd4 : 5'd0});
        wait_cfg = w;
        start = done_seen;
        @(negedge clk);
        trap_req = t; emu_req = em; trap_num = n;
        cur_pc = pc; cur_status = st; sys_sp = sp; tbl_base = base;
        @(negedge clk);
        trap_req = 1'b0; emu_req = 1'b0;
        cur_pc = 32'hDEAD_0000; sys_sp = 32'h0BAD_0000;
        if (inject) begin
            @(negedge clk);
            // R10: requests during a stalled push
            trap_req = 1'b1; trap_num = 8'd99;
            @(negedge clk);
            emu_req = 1'b1;
            @(negedge clk);
            trap_req = 1'b0; emu_req = 1'b0;
        end
        while (done_seen == start) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!busy && sb.size() == 0, "R2 R10 idle after sequence",
            {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_wr && !mem_rd, "R1 reset state",
            {28'd0, busy, done, mem_wr, mem_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 ordinary trap, no wait states
        run_trap(1'b1, 1'b0, 8'd5, 32'h0000_1000, 32'h001F_0030, 32'h0000_8000,
                 32'h000F_FC00, 0, 1'b0);
        // R6 emulator trap with stalls
        run_trap(1'b0, 1'b1, 8'd200, 32'h0040_2002, 32'hF0F0_1234, 32'h0001_0000,
                 32'h0010_0000, 2, 1'b0);
        // R5 vector 0 wraps past the top of the address space
        run_trap(1'b1, 1'b0, 8'd0, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_2000,
                 32'hFFFF_FF00, 1, 1'b0);
        // R5 vector 255 lands on the table base
        run_trap(1'b1, 1'b0, 8'd255, 32'h0000_3000, 32'h1234_5678, 32'h0000_4000,
                 32'h2000_0000, 0, 1'b0);
        // R2 both requests: the emulator variant wins
        run_trap(1'b1, 1'b1, 8'd3, 32'h0000_5000, 32'h0000_00FF, 32'h0000_6000,
                 32'h0000_0000, 1, 1'b0);
        // R10 requests while busy are dropped
        run_trap(1'b1, 1'b0, 8'd7, 32'h0000_7000, 32'hAAAA_5555, 32'h0000_9000,
                 32'h0003_0000, 3, 1'b1);
        // R8 stack pointer wraps below zero
        run_trap(1'b1, 1'b0, 8'd12, 32'h0000_8000, 32'h0000_0F00, 32'h0000_0004,
                 32'h0000_1000, 0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule